// File: doc/BRIEF.md
# Single-Precision Compare Condition-Code Unit

This unit compares two IEEE-754 single-precision values and stores the outcome as a two-bit condition code in one of four condition fields of a floating-point status word. The caller supplies the operands, a field selector and the present status word, then pulses `start_i`. One clock later `fsr_o` carries the updated status word and `done_o` pulses for one cycle.

If either operand is a NaN, the compare is unordered. How that result is handled depends on the invalid-trap enable bit of the incoming status word. When the bit is set, the unit raises a one-cycle exception request. When it is clear, the unit sets the sticky invalid-accrued bit. Positive and negative zero compare equal. All other values are ordered by sign and magnitude.

Top module: `fcmp_cc_unit`

## Requirements
- R1: While `rst_n` is low, `fsr_o` is all zeros and `done_o` and `exc_req_o` are 0.
- R2: A `start_i` pulse in cycle N makes `done_o` 1 in cycle N+1 and loads the new status word into `fsr_o` in that same cycle. With no start, `done_o` is 0 and `fsr_o` holds its value whatever the other inputs do.
- R3: The written code is 2'b00 for equal, 2'b01 for a < b, 2'b10 for a > b and 2'b11 for unordered. Both bits of the selected field are replaced, whatever value they held before.
- R4: `fsel_i` values 0, 1, 2 and 3 select status bits [1:0], [23:22], [25:24] and [27:26] respectively.
- R5: An operand with exponent bits [30:23] all ones and a nonzero fraction [22:0] is a NaN, quiet or signalling. A NaN in either operand gives an unordered result.
- R6: +0 (32'h00000000) and -0 (32'h80000000) compare equal to each other and to themselves.
- R7: Non-NaN values are ordered as real numbers, infinities included. A negative value is less than a positive one. When both values are negative, the larger magnitude is the smaller value.
- R8: On an unordered result with status bit 10 (invalid-trap enable) set, `exc_req_o` pulses together with `done_o`, and the accrued bit 5 keeps its incoming value.
- R9: On an unordered result with bit 10 clear, status bit 5 (invalid accrued) is set and `exc_req_o` stays 0. An ordered result never raises `exc_req_o` and passes bit 5 through unchanged, so a set bit stays set.
- R10: Every status bit outside the selected field and bit 5 is copied from `fsr_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Compare request strobe |
| op_a_i | input | 32 | First single-precision operand |
| op_b_i | input | 32 | Second single-precision operand |
| fsel_i | input | 2 | Condition field selector |
| fsr_i | input | 32 | Current status word |
| fsr_o | output | 32 | Updated status word, registered |
| done_o | output | 1 | One-cycle completion pulse |
| exc_req_o | output | 1 | One-cycle exception request |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency of the done pulse;
- that the status word holds when idle;
- that an exception request only comes with a done pulse and an unordered code;
- that bits outside the field and the accrued bit pass through unchanged;
- that a set accrued bit is never cleared.

The bench scenarios are needed for the rest. These are the real-number ordering (signed zeros, infinities and negative pairs), NaN detection for both NaN kinds, the exact code written into each field offset, and the choice between trap and sticky flag.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FSR_W  = 32;
  localparam int CC_W   = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [CC_W-1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  // Low bit position of each condition field; fixed by the status-word layout.
  function automatic int unsigned cc_lsb(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 22;
      2'd2:    return 24;
      default: return 26;
    endcase
  endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] op_i,
  output logic         nan_o,
  output logic         zero_o,
  output logic         sign_o,
  output logic [W-2:0] mag_o
);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f  = op_i[W-2 -: EXP_W];
    frac_f = op_i[FRAC_W-1:0];
    sign_o = op_i[W-1];
    mag_o  = op_i[W-2:0];
    nan_o  = (&exp_f) && (|frac_f);
    zero_o = ~(|op_i[W-2:0]);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         a_nan_i,
  input  logic         a_zero_i,
  input  logic         a_sign_i,
  input  logic [W-2:0] a_mag_i,
  input  logic         b_nan_i,
  input  logic         b_zero_i,
  input  logic         b_sign_i,
  input  logic [W-2:0] b_mag_i,
  output rel_e         rel_o
);
  logic mag_lt, mag_eq;

  always_comb begin
    mag_lt = a_mag_i < b_mag_i;
    mag_eq = a_mag_i == b_mag_i;
    if (a_nan_i || b_nan_i) begin
      rel_o = REL_UN;
    end else if (a_zero_i && b_zero_i) begin
      rel_o = REL_EQ;
    end else if (a_sign_i != b_sign_i) begin
      rel_o = a_sign_i ? REL_LT : REL_GT;
    end else if (mag_eq && (a_sign_i == b_sign_i)) begin
      rel_o = REL_EQ;
    end else if (a_sign_i) begin
      rel_o = mag_lt ? REL_GT : REL_LT;
    end else begin
      rel_o = mag_lt ? REL_LT : REL_GT;
    end
  end
endmodule

// File: rtl/fcmp_fsr_merge.sv
module fcmp_fsr_merge
  import fcmp_pkg::*;
#(
  parameter int FW           = 32,
  parameter int INV_TRAP_POS = 10,
  parameter int ACC_POS      = 5
) (
  input  logic [FW-1:0]    fsr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  rel_e             rel_i,
  output logic [FW-1:0]    fsr_o,
  output logic             trap_o
);
  logic [FW-1:0] field_mask, field_code;
  logic          unord;

  always_comb begin
    field_mask = FW'(2'b11) << cc_lsb(sel_i);
    field_code = FW'(rel_i) << cc_lsb(sel_i);
    unord      = (rel_i == REL_UN);
    trap_o     = unord && fsr_i[INV_TRAP_POS];
    fsr_o      = (fsr_i & ~field_mask) | field_code;
    if (unord && !fsr_i[INV_TRAP_POS]) begin
      fsr_o[ACC_POS] = 1'b1;
    end
  end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcmp_pkg::*;
#(
  parameter int INV_TRAP_POS = 10,
  parameter int ACC_POS      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [SEL_W-1:0]  fsel_i,
  input  logic [FSR_W-1:0]  fsr_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic              done_o,
  output logic              exc_req_o
);
  localparam int NOPS = 2;

  logic [WORD_W-1:0] ops     [NOPS];
  logic              op_nan  [NOPS];
  logic              op_zero [NOPS];
  logic              op_sign [NOPS];
  logic [WORD_W-2:0] op_mag  [NOPS];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
    fcmp_classify #(.W(WORD_W), .EXP_W(EXP_W)) u_cls (
      .op_i   (ops[gi]),
      .nan_o  (op_nan[gi]),
      .zero_o (op_zero[gi]),
      .sign_o (op_sign[gi]),
      .mag_o  (op_mag[gi])
    );
  end

  rel_e rel;

  fcmp_order #(.W(WORD_W)) u_ord (
    .a_nan_i  (op_nan[0]),
    .a_zero_i (op_zero[0]),
    .a_sign_i (op_sign[0]),
    .a_mag_i  (op_mag[0]),
    .b_nan_i  (op_nan[1]),
    .b_zero_i (op_zero[1]),
    .b_sign_i (op_sign[1]),
    .b_mag_i  (op_mag[1]),
    .rel_o    (rel)
  );

  logic [FSR_W-1:0] merged;
  logic             trap;

  fcmp_fsr_merge #(.FW(FSR_W), .INV_TRAP_POS(INV_TRAP_POS), .ACC_POS(ACC_POS)) u_mrg (
    .fsr_i  (fsr_i),
    .sel_i  (fsel_i),
    .rel_i  (rel),
    .fsr_o  (merged),
    .trap_o (trap)
  );

  logic [FSR_W-1:0] fsr_q, fsr_d;
  logic             done_q, done_d, exc_q, exc_d;

  always_comb begin
    fsr_d  = fsr_q;
    done_d = start_i;
    exc_d  = start_i && trap;
    if (start_i) begin
      fsr_d = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q  <= '0;
      done_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      fsr_q  <= fsr_d;
      done_q <= done_d;
      exc_q  <= exc_d;
    end
  end

  assign fsr_o     = fsr_q;
  assign done_o    = done_q;
  assign exc_req_o = exc_q;
endmodule

// File: rtl/fcmp_cc_checker.sv
module fcmp_cc_checker
  import fcmp_pkg::*;
#(
  parameter int ACC_POS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [SEL_W-1:0] fsel_i,
  input logic [FSR_W-1:0] fsr_i,
  input logic [FSR_W-1:0] fsr_o,
  input logic             done_o,
  input logic             exc_req_o
);
  function automatic logic [FSR_W-1:0] touch_mask(input logic [SEL_W-1:0] s);
    logic [FSR_W-1:0] m;
    m = FSR_W'(2'b11) << cc_lsb(s);
    m[ACC_POS] = 1'b1;
    return m;
  endfunction

  function automatic logic [CC_W-1:0] field_of(input logic [FSR_W-1:0] f,
                                               input logic [SEL_W-1:0] s);
    return CC_W'(f >> cc_lsb(s));
  endfunction

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(fsr_o));

  p_exc_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> done_o);

  p_exc_unordered_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!exc_req_o || field_of(fsr_o, $past(fsel_i)) == 2'b11));

  p_exc_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!exc_req_o || fsr_o[ACC_POS] == $past(fsr_i[ACC_POS])));

  p_acc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && fsr_i[ACC_POS]) |=> fsr_o[ACC_POS]);

  p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (((fsr_o ^ $past(fsr_i)) & ~touch_mask($past(fsel_i))) == '0));
endmodule

bind fcmp_cc_unit fcmp_cc_checker #(.ACC_POS(ACC_POS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .fsel_i    (fsel_i),
  .fsr_i     (fsr_i),
  .fsr_o     (fsr_o),
  .done_o    (done_o),
  .exc_req_o (exc_req_o)
);

// File: tb/fcmp_cc_unit_tb.sv
module fcmp_cc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] op_a_i, op_b_i, fsr_i;
  logic [1:0]  fsel_i;
  logic [31:0] fsr_o;
  logic        done_o, exc_req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fcmp_cc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .fsel_i(fsel_i), .fsr_i(fsr_i), .fsr_o(fsr_o), .done_o(done_o), .exc_req_o(exc_req_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  // Signed key: equal keys mean equal reals, both zeros map to 0.
  function automatic logic signed [32:0] key(input logic [31:0] v);
    logic signed [32:0] m;
    m = $signed({2'b00, v[30:0]});
    return v[31] ? -m : m;
  endfunction

  function automatic logic [1:0] ref_code(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 2'b11;
    if (key(a) == key(b)) return 2'b00;
    if (key(a) < key(b)) return 2'b01;
    return 2'b10;
  endfunction

  function automatic int ref_lsb(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 22;
      2'd2: return 24;
      default: return 26;
    endcase
  endfunction

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] s,
                       input logic [31:0] f, input string tag);
    logic [1:0]  c;
    logic [31:0] ef;
    logic        ex;
    c  = ref_code(a, b);
    ef = f;
    ef[ref_lsb(s) +: 2] = c;
    ex = (c == 2'b11) && f[10];
    if (c == 2'b11 && !f[10]) ef[5] = 1'b1;
    op_a_i = a; op_b_i = b; fsel_i = s; fsr_i = f; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1, {tag, " R2 done"}, 32'(done_o), 32'd1);
    chk(fsr_o == ef, {tag, " R3/R4/R10 fsr"}, fsr_o, ef);
    chk(exc_req_o == ex, {tag, " R8/R9 exc"}, 32'(exc_req_o), 32'(ex));
    fsr_i = $urandom; op_a_i = $urandom; fsel_i = 2'($urandom);
    @(negedge clk);
    chk(done_o == 1'b0 && exc_req_o == 1'b0, {tag, " R2 idle pulse"},
        32'({done_o, exc_req_o}), 32'd0);
    chk(fsr_o == ef, {tag, " R2 hold"}, fsr_o, ef);
  endtask

  function automatic logic [31:0] pick();
    logic s;
    s = 1'($urandom);
    case ($urandom % 6)
      0: return {s, 8'hff, 23'($urandom) | 23'd1};
      1: return {s, 31'd0};
      2: return {s, 8'hff, 23'd0};
      3: return {s, 31'($urandom % 16)};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 1'b1; op_a_i = 0; op_b_i = 0; fsel_i = 0; fsr_i = '1;
    repeat (3) @(negedge clk);
    chk(fsr_o == 0 && !done_o && !exc_req_o, "R1 reset state", fsr_o, 32'd0);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 signed zeros, every field (R4)
    for (int s = 0; s < 4; s++) do_op(32'h0000_0000, 32'h8000_0000, 2'(s), 32'h0FC0_0003, "R6 zeros");
    do_op(32'h8000_0000, 32'h8000_0000, 2'd2, 32'h0, "R6 negzero");
    // R7 ordering
    do_op(32'h3f80_0000, 32'h4000_0000, 2'd1, 32'h0, "R7 1<2");
    do_op(32'hbf80_0000, 32'hc000_0000, 2'd3, 32'h0, "R7 -1>-2");
    do_op(32'hff80_0000, 32'h7f80_0000, 2'd0, 32'h0, "R7 -inf<inf");
    do_op(32'h4000_0000, 32'hbf80_0000, 2'd0, 32'h3, "R7 pos>neg");
    // R5 signalling and quiet NaN; R9 sticky; R8 trap
    do_op(32'h7f80_0001, 32'h3f80_0000, 2'd1, 32'h0, "R5/R9 snan");
    do_op(32'h3f80_0000, 32'h7fc0_0000, 2'd2, 32'h400, "R5/R8 qnan trap");
    do_op(32'h3f80_0000, 32'h3f80_0000, 2'd3, 32'h0C00_0020, "R3/R9 eq keeps acc");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = pick();
      case ($urandom % 4)
        0: b = a;
        1: b = a ^ 32'h8000_0000;
        default: b = pick();
      endcase
      do_op(a, b, 2'($urandom), $urandom, "R3/R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule